// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a conditional branch in a 32-bit, single-bus processor is taken. It decodes the branch fields of the instruction word and picks out the general register that the sequencer must drive onto the shared bus. It also forms the sign-extended displacement that the ALU adds to the incremented program counter.

During one control step the sequencer raises a capture strobe, and the bus then carries the selected register's value. The unit tests that value against the condition code and stores the verdict in a condition flip-flop. Several steps later, once the ALU has formed the target address, the sequencer requests a program-counter load. For a branch instruction, the unit passes that request on only if the stored verdict is true, so an untaken branch leaves the PC unchanged. For any other opcode, the request passes through ungated.

The verdict is sampled in the strobe step and held until the next capture. It is not re-evaluated at the moment of the PC write. This lets the bus be reused for the PC and ALU transfers in between.

Top module: `brcond_unit`

## Requirements
- R1: While `clr` is high, `cond_flag` is 0. After `clr` is released it stays 0 until a capture strobe, so a branch PC-load request is blocked.
- R2: An instruction is a branch when bits 31:27 equal 5'b10011. For any other opcode, `pc_load_en` equals `pc_load_req` whatever the value of `cond_flag`.
- R3: `src_reg_sel` equals instruction bits 26:23; for example, 4'b0110 selects register 6.
- R4: With condition code 2'b00 in instruction bits 20:19, a capture sets `cond_flag` to 1 exactly when the bus value is zero.
- R5: With condition code 2'b01, a capture sets `cond_flag` to 1 exactly when the bus value is nonzero.
- R6: With condition code 2'b10, a capture sets `cond_flag` to 1 exactly when bus bit 31 is 0 and the value is nonzero.
- R7: With condition code 2'b11, a capture sets `cond_flag` to 1 exactly when bus bit 31 is 1.
- R8: `cond_flag` changes only on a rising clock edge at which `cond_strobe` is high. Otherwise it holds its value, whatever the bus and instruction do.
- R9: For a branch instruction, `pc_load_en` is `pc_load_req` AND `cond_flag`.
- R10: `branch_imm` is instruction bits 18:0, sign-extended from bit 18 to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| clr | input | 1 | Asynchronous active-high clear of the condition flag |
| instr | input | 32 | Current instruction word |
| bus | input | 32 | Shared data bus carrying the tested register |
| cond_strobe | input | 1 | Capture strobe for the condition flag |
| pc_load_req | input | 1 | PC-load request from the sequencer |
| cond_flag | output | 1 | Stored branch verdict |
| pc_load_en | output | 1 | Gated program-counter load enable |
| src_reg_sel | output | 4 | Index of the register to drive onto the bus |
| branch_imm | output | 32 | Sign-extended branch displacement |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 5-bit opcode at the top of the word, a 4-bit register index and a 19-bit displacement. With these values the bus sign bit and the displacement sign bit are both reachable with directed values. The bench checks every condition code against zero, small positive, largest positive, most negative and all-ones operands. It follows each capture with an idle step in which the bus and condition code change, so a flag that leaked through without the strobe would show at `pc_load_en`.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    typedef enum logic [1:0] {
        CC_ZERO    = 2'b00,
        CC_NONZERO = 2'b01,
        CC_POS     = 2'b10,
        CC_NEG     = 2'b11
    } cc_e;

    localparam int unsigned CC_W     = 2;
    localparam int unsigned CC_COUNT = 1 << CC_W;

    typedef struct packed {
        logic cond;
    } flag_state_t;

endpackage

// File: rtl/brcond_decode.sv
module brcond_decode #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OPC_W   = 5,
    parameter int unsigned OPC_LSB = 27,
    parameter logic [OPC_W-1:0] BR_OPC = 5'b10011,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned SEL_LSB = 23,
    parameter int unsigned CC_LSB  = 19,
    parameter int unsigned IMM_W   = 19
) (
    input  logic [INSTR_W-1:0]          instr,
    output logic                        is_branch,
    output logic [SEL_W-1:0]            sel,
    output logic [brcond_pkg::CC_W-1:0] cc,
    output logic [DATA_W-1:0]           imm
);
    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic unused_spare;

    always_comb begin
        is_branch = (instr[OPC_LSB +: OPC_W] == BR_OPC);
        sel       = instr[SEL_LSB +: SEL_W];
        cc        = instr[CC_LSB +: brcond_pkg::CC_W];
        imm       = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    end

    assign unused_spare = ^instr;

endmodule

// File: rtl/brcond_test.sv
module brcond_test #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]           value,
    input  logic [brcond_pkg::CC_W-1:0] cc,
    output logic                        pass
);
    import brcond_pkg::*;

    logic                is_zero;
    logic                is_neg;
    logic [CC_COUNT-1:0] hit;

    assign is_zero = ~|value;
    assign is_neg  = value[DATA_W-1];

    generate
        for (genvar g = 0; g < CC_COUNT; g++) begin : g_cc
            if (g == int'(CC_ZERO)) begin : g_z
                assign hit[g] = is_zero;
            end else if (g == int'(CC_NONZERO)) begin : g_nz
                assign hit[g] = !is_zero;
            end else if (g == int'(CC_POS)) begin : g_p
                assign hit[g] = !is_neg && !is_zero;
            end else begin : g_n
                assign hit[g] = is_neg;
            end
        end
    endgenerate

    assign pass = hit[cc];

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OPC_W   = 5,
    parameter int unsigned OPC_LSB = 27,
    parameter logic [OPC_W-1:0] BR_OPC = 5'b10011,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned SEL_LSB = 23,
    parameter int unsigned CC_LSB  = 19,
    parameter int unsigned IMM_W   = 19
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  bus,
    input  logic               cond_strobe,
    input  logic               pc_load_req,
    output logic               cond_flag,
    output logic               pc_load_en,
    output logic [SEL_W-1:0]   src_reg_sel,
    output logic [DATA_W-1:0]  branch_imm
);
    import brcond_pkg::*;

    logic              is_branch;
    logic [CC_W-1:0]   cc;
    logic              test_pass;
    flag_state_t       st_d;
    flag_state_t       st_q;

    brcond_decode #(
        .INSTR_W(INSTR_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .OPC_LSB(OPC_LSB),
        .BR_OPC(BR_OPC), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB), .CC_LSB(CC_LSB),
        .IMM_W(IMM_W)
    ) i_decode (
        .instr    (instr),
        .is_branch(is_branch),
        .sel      (src_reg_sel),
        .cc       (cc),
        .imm      (branch_imm)
    );

    brcond_test #(
        .DATA_W(DATA_W)
    ) i_test (
        .value(bus),
        .cc   (cc),
        .pass (test_pass)
    );

    // Next-state: capture the verdict only in the strobe step.
    always_comb begin
        st_d = st_q;
        if (cond_strobe) begin
            st_d.cond = test_pass;
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_flag  = st_q.cond;
    assign pc_load_en = is_branch ? (pc_load_req && st_q.cond) : pc_load_req;

endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OPC_W   = 5,
    parameter int unsigned OPC_LSB = 27,
    parameter logic [OPC_W-1:0] BR_OPC = 5'b10011,
    parameter int unsigned CC_LSB  = 19
) (
    input logic               clk,
    input logic               clr,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  bus,
    input logic               cond_strobe,
    input logic               pc_load_req,
    input logic               cond_flag,
    input logic               pc_load_en
);
    logic [1:0] cc_c;
    logic       br_c;

    assign cc_c = instr[CC_LSB +: 2];
    assign br_c = (instr[OPC_LSB +: OPC_W] == BR_OPC);

    // R1
    clear_flag_chk: assert property (@(posedge clk) clr |=> !cond_flag);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (clr)
        !br_c |-> (pc_load_en == pc_load_req));

    // R4
    zero_test_chk: assert property (@(posedge clk) disable iff (clr)
        (cond_strobe && cc_c == 2'b00) |=> (cond_flag == ($past(bus) == '0)));

    // R5
    nonzero_test_chk: assert property (@(posedge clk) disable iff (clr)
        (cond_strobe && cc_c == 2'b01) |=> (cond_flag == ($past(bus) != '0)));

    // R6
    positive_test_chk: assert property (@(posedge clk) disable iff (clr)
        (cond_strobe && cc_c == 2'b10) |=>
        (cond_flag == (!$past(bus[DATA_W-1]) && ($past(bus) != '0))));

    // R7
    negative_test_chk: assert property (@(posedge clk) disable iff (clr)
        (cond_strobe && cc_c == 2'b11) |=> (cond_flag == $past(bus[DATA_W-1])));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (clr)
        !cond_strobe |=> $stable(cond_flag));

    // R9
    gated_load_chk: assert property (@(posedge clk) disable iff (clr)
        br_c |-> (pc_load_en == (pc_load_req && cond_flag)));

endmodule

bind brcond_unit brcond_unit_chk #(
    .INSTR_W(INSTR_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .OPC_LSB(OPC_LSB),
    .BR_OPC(BR_OPC), .CC_LSB(CC_LSB)
) i_brcond_unit_chk (
    .clk(clk), .clr(clr), .instr(instr), .bus(bus), .cond_strobe(cond_strobe),
    .pc_load_req(pc_load_req), .cond_flag(cond_flag), .pc_load_en(pc_load_en)
);

// File: tb/test_brcond_unit.sv
module test_brcond_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [31:0] instr = '0;
    logic [31:0] bus = '0;
    logic        cond_strobe = 1'b0;
    logic        pc_load_req = 1'b0;
    logic        cond_flag;
    logic        pc_load_en;
    logic [3:0]  src_reg_sel;
    logic [31:0] branch_imm;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brcond_unit i_brcond_unit (
        .clk(clk), .clr(clr), .instr(instr), .bus(bus), .cond_strobe(cond_strobe),
        .pc_load_req(pc_load_req), .cond_flag(cond_flag), .pc_load_en(pc_load_en),
        .src_reg_sel(src_reg_sel), .branch_imm(branch_imm)
    );

    function automatic logic [31:0] mk_br(input logic [3:0] rs, input logic [1:0] cc,
                                          input logic [18:0] imm);
        return {5'b10011, rs, 2'b00, cc, imm};
    endfunction

    function automatic logic expect_cc(input logic [1:0] cc, input logic [31:0] v);
        case (cc)
            2'b00:   return v == 32'd0;
            2'b01:   return v != 32'd0;
            2'b10:   return !v[31] && v != 32'd0;
            default: return v[31];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Capture step then idle step with PC-load request; checks at negedge+1.
    task automatic capture(input logic [31:0] ins, input logic [31:0] v);
        @(negedge clk);
        instr = ins; bus = v; cond_strobe = 1'b1; pc_load_req = 1'b0;
        @(negedge clk);
        cond_strobe = 1'b0; pc_load_req = 1'b1;
        bus = ~v; instr = ins ^ 32'h0018_0000;
        #1;
    endtask

    task automatic t_reset();
        clr = 1'b1;
        instr = mk_br(4'd6, 2'b01, 19'd25);
        pc_load_req = 1'b1;
        #(CLK_PERIOD*2 + 1);
        check("R1 flag in clear", {31'd0, cond_flag}, 32'd0);
        check("R1 load blocked in clear", {31'd0, pc_load_en}, 32'd0);
        @(negedge clk); clr = 1'b0;
        @(negedge clk); #1;
        check("R1 flag after release", {31'd0, cond_flag}, 32'd0);
        check("R1 load blocked after release", {31'd0, pc_load_en}, 32'd0);
        pc_load_req = 1'b0;
    endtask

    task automatic t_cond(input logic [1:0] cc, input string req);
        logic [31:0] vals [5] = '{32'd0, 32'd5, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
        for (int i = 0; i < 5; i++) begin
            logic e;
            e = expect_cc(cc, vals[i]);
            capture(mk_br(4'd6, cc, 19'd25), vals[i]);
            check(req, {31'd0, cond_flag}, {31'd0, e});
            // R8: bus and cc changed without strobe; flag must hold
            check("R8 hold after idle step", {31'd0, cond_flag}, {31'd0, e});
            // R9: gated load for the branch
            check("R9 gated load", {31'd0, pc_load_en}, {31'd0, e});
        end
    endtask

    task automatic t_hold();
        capture(mk_br(4'd2, 2'b00, 19'd0), 32'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus = 32'h1234_0000 + i; instr = mk_br(4'd2, 2'(i), 19'd0);
            cond_strobe = 1'b0;
            #1;
            check("R8 held without strobe", {31'd0, cond_flag}, 32'd1);
        end
        pc_load_req = 1'b0; #1;
        check("R9 no request no load", {31'd0, pc_load_en}, 32'd0);
    endtask

    task automatic t_passthru();
        capture(mk_br(4'd1, 2'b00, 19'd0), 32'd9);
        check("R2 setup flag false", {31'd0, cond_flag}, 32'd0);
        instr = 32'h1B18_0019; pc_load_req = 1'b1; #1;
        check("R2 non-branch passes request", {31'd0, pc_load_en}, 32'd1);
        pc_load_req = 1'b0; #1;
        check("R2 non-branch no request", {31'd0, pc_load_en}, 32'd0);
        instr = mk_br(4'd1, 2'b00, 19'd0); pc_load_req = 1'b1; #1;
        check("R9 branch blocked when false", {31'd0, pc_load_en}, 32'd0);
        pc_load_req = 1'b0;
    endtask

    task automatic t_fields();
        for (int r = 0; r < 16; r += 5) begin
            instr = mk_br(4'(r), 2'b11, 19'd0); #1;
            check("R3 register select", {28'd0, src_reg_sel}, 32'(r));
        end
        instr = 32'h9B18_0019; #1;
        check("R3 select six", {28'd0, src_reg_sel}, 32'd6);
        check("R10 positive displacement", branch_imm, 32'd25);
        instr = mk_br(4'd6, 2'b00, 19'h7FFFF); #1;
        check("R10 minus one", branch_imm, 32'hFFFF_FFFF);
        instr = mk_br(4'd6, 2'b00, 19'h40000); #1;
        check("R10 most negative", branch_imm, 32'hFFFC_0000);
        instr = mk_br(4'd6, 2'b00, 19'h3FFFF); #1;
        check("R10 most positive", branch_imm, 32'h0003_FFFF);
    endtask

    task automatic t_reclear();
        capture(mk_br(4'd3, 2'b11, 19'd0), 32'h8000_0001);
        check("R7 setup flag true", {31'd0, cond_flag}, 32'd1);
        #2 clr = 1'b1; #1;
        check("R1 async clear", {31'd0, cond_flag}, 32'd0);
        @(negedge clk); clr = 1'b0; pc_load_req = 1'b0;
    endtask

    initial begin
        t_reset();
        t_cond(2'b00, "R4 zero test");
        t_cond(2'b01, "R5 nonzero test");
        t_cond(2'b10, "R6 positive test");
        t_cond(2'b11, "R7 negative test");
        t_hold();
        t_passthru();
        t_fields();
        t_reclear();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule